// File: doc/BRIEF.md
# Burst Memory Write-Read Self-Test

This block drives traffic into the user side of a burst memory controller and checks what comes back. It holds off until the controller reports that calibration is done. It then runs a loop that never ends. Each loop writes a group of bursts to consecutive burst slots, reads the same slots back in the same order, and compares every returned beat against a pattern it regenerates on the fly. Because the pattern depends only on the address and the beat number, no write data is stored.

A command is one cycle of `cmd_valid`, with `cmd_write` set for a write and clear for a read. A burst carries burst-length/4 beats of 4*DQ_W bits. The address of a burst is its slot number times the beat count. Slots run around a test region that is set by a parameter. The region resumes where the previous loop stopped.

A mismatch raises `err`, which stays high until reset. `pass_count` advances once for every loop that saw no mismatch, so a later clean loop is still counted after an earlier failure.

Top module: `mem_burst_selftest`

## Requirements
- R1: While `calib_done` has not yet been seen high since reset, `cmd_valid` stays low.
- R2: A loop opens with NUM_BURSTS write commands (`cmd_valid`=1, `cmd_write`=1) spaced exactly BEATS cycles apart. The command cycle carries write beat 0 on `wdata`, and the following BEATS-1 cycles carry beats 1 to BEATS-1.
- R3: BEATS cycles after the last write command, NUM_BURSTS read commands (`cmd_write`=0) follow, spaced BEATS cycles apart, to the same addresses in the same order.
- R4: A burst in slot s uses `cmd_addr` = s*BEATS. Each new burst takes the next slot, and slot REGION_BURSTS-1 is followed by slot 0. The first loop after reset starts at slot 0, and each later loop starts at the slot after the last one used.
- R5: Lane j (bits 32j+31 to 32j) of beat b in the burst at address A equals {(A[15:0] xor A[31:16] xor 16'hC3A5), b[7:0], j[7:0]}, with A zero-extended to 32 bits.
- R6: `wmask` is all zeros, so every byte is written.
- R7: A returned beat is taken only when `rdata_valid` is high during the read or drain part of a loop. Valid beats during the write part are ignored. After NUM_BURSTS*BEATS beats have been taken, the first write command of the next loop appears two cycles after the cycle that carried the final beat.
- R8: A taken beat that differs from its expected pattern sets `err`, and `err` stays set until reset.
- R9: At the end of each loop, `pass_count` rises by one if that loop had no mismatch and stays unchanged otherwise, whatever the state of `err`.
- R10: Reset clears `err` and `pass_count`, drops `cmd_valid`, and restarts the sequence at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| calib_done | input | 1 | Memory controller calibration finished |
| cmd_valid | output | 1 | Command strobe |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Burst start address |
| wdata | output | 4*DQ_W | Write beat |
| wmask | output | DQ_W/2 | Byte mask, high = skip byte |
| rdata | input | 4*DQ_W | Read beat |
| rdata_valid | input | 1 | Read beat present |
| err | output | 1 | Sticky mismatch flag |
| pass_count | output | PASS_W | Number of clean loops |

## Verification
Issuing the next read command and checking a beat returned for an earlier read can fall in the same cycle. The bench memory model answers each read three cycles after the command. Because read commands are BEATS cycles apart, later read commands are issued while earlier bursts are still streaming back. The bench judges the overlap through a table of expected commands and spacings, a steady `err`, and a `pass_count` that rises by one per loop. A further loop runs the same overlap with idle gaps inserted into the returned data and with spurious valid beats during writes.

// File: rtl/mst_pkg.sv
package mst_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_WRITE = 2'd1,
      PH_READ  = 2'd2,
      PH_DRAIN = 2'd3
   } phase_t;

   localparam logic [15:0] PAT_KEY = 16'hC3A5;

   // counter width for a count of n values, never below one bit
   function automatic int cw(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mst_pattern.sv
module mst_pattern #(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 64,
   parameter int BEAT_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BEAT_W-1:0] beat,
   output logic [DATA_W-1:0] word
);
   localparam int LANES = DATA_W / 32;

   logic [31:0] a_ext;
   logic [15:0] fold;

   assign a_ext = 32'(addr);
   assign fold  = a_ext[15:0] ^ a_ext[31:16] ^ mst_pkg::PAT_KEY;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign word[32*j +: 32] = {fold, 8'(beat), 8'(j)};
   end
endmodule

// File: rtl/mst_issue.sv
module mst_issue #(
   parameter int ADDR_W        = 21,
   parameter int NUM_BURSTS    = 4,
   parameter int REGION_BURSTS = 6,
   parameter int BEATS         = 32,
   parameter int BEAT_W        = mst_pkg::cw(BEATS),
   parameter int SLOT_W        = mst_pkg::cw(REGION_BURSTS),
   parameter int BURST_W       = mst_pkg::cw(NUM_BURSTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              calib_done,
   input  logic              loop_done,
   output logic              cmd_valid,
   output logic              cmd_write,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [BEAT_W-1:0] beat_idx,
   output logic [SLOT_W-1:0] base_slot,
   output logic              rx_en
);
   import mst_pkg::*;

   phase_t             phase_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [BURST_W-1:0] burst_q;
   logic [SLOT_W-1:0]  slot_q, base_q, slot_nxt, base_nxt;
   logic [SLOT_W:0]    base_sum;
   logic               last_beat, last_burst;

   always_comb begin
      last_beat  = (beat_q == BEAT_W'(BEATS - 1));
      last_burst = (burst_q == BURST_W'(NUM_BURSTS - 1));
      slot_nxt   = (slot_q == SLOT_W'(REGION_BURSTS - 1)) ? '0 : slot_q + 1'b1;
      base_sum   = {1'b0, base_q} + (SLOT_W+1)'(NUM_BURSTS);
      base_nxt   = (base_sum >= (SLOT_W+1)'(REGION_BURSTS))
                 ? SLOT_W'(base_sum - (SLOT_W+1)'(REGION_BURSTS))
                 : base_sum[SLOT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         beat_q  <= '0;
         burst_q <= '0;
         slot_q  <= '0;
         base_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (calib_done) begin
                  phase_q <= PH_WRITE;
                  slot_q  <= base_q;
                  beat_q  <= '0;
                  burst_q <= '0;
               end
            end
            PH_WRITE: begin
               if (last_beat) begin
                  beat_q <= '0;
                  if (last_burst) begin
                     burst_q <= '0;
                     slot_q  <= base_q;
                     phase_q <= PH_READ;
                  end else begin
                     burst_q <= burst_q + 1'b1;
                     slot_q  <= slot_nxt;
                  end
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            PH_READ: begin
               beat_q <= last_beat ? '0 : beat_q + 1'b1;
               if (beat_q == '0) begin
                  slot_q <= slot_nxt;
                  if (last_burst) begin
                     burst_q <= '0;
                     beat_q  <= '0;
                     phase_q <= PH_DRAIN;
                  end else begin
                     burst_q <= burst_q + 1'b1;
                  end
               end
            end
            PH_DRAIN: begin
               if (loop_done) begin
                  phase_q <= PH_WRITE;
                  base_q  <= base_nxt;
                  slot_q  <= base_nxt;
                  beat_q  <= '0;
                  burst_q <= '0;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign cmd_valid = ((phase_q == PH_WRITE) || (phase_q == PH_READ)) && (beat_q == '0);
   assign cmd_write = (phase_q == PH_WRITE);
   assign cmd_addr  = ADDR_W'(32'(slot_q) * 32'(BEATS));
   assign beat_idx  = beat_q;
   assign base_slot = base_q;
   assign rx_en     = ((phase_q == PH_READ) || (phase_q == PH_DRAIN)) && !loop_done;
endmodule

// File: rtl/mst_rd_check.sv
module mst_rd_check #(
   parameter int ADDR_W        = 21,
   parameter int DATA_W        = 64,
   parameter int NUM_BURSTS    = 4,
   parameter int REGION_BURSTS = 6,
   parameter int BEATS         = 32,
   parameter int PASS_W        = 16,
   parameter int BEAT_W        = mst_pkg::cw(BEATS),
   parameter int SLOT_W        = mst_pkg::cw(REGION_BURSTS),
   parameter int BURST_W       = mst_pkg::cw(NUM_BURSTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              rdata_valid,
   input  logic [DATA_W-1:0] rdata,
   input  logic [SLOT_W-1:0] base_slot,
   output logic              err,
   output logic [PASS_W-1:0] pass_count,
   output logic              loop_done
);
   logic [BEAT_W-1:0]  beat_q;
   logic [BURST_W-1:0] burst_q;
   logic               bad_q, err_q, done_q;
   logic [PASS_W-1:0]  pass_q;
   logic [SLOT_W:0]    slot_sum;
   logic [SLOT_W-1:0]  exp_slot;
   logic [ADDR_W-1:0]  exp_addr;
   logic [DATA_W-1:0]  exp_word;
   logic               take, miss;

   always_comb begin
      slot_sum = {1'b0, base_slot} + (SLOT_W+1)'(burst_q);
      exp_slot = (slot_sum >= (SLOT_W+1)'(REGION_BURSTS))
               ? SLOT_W'(slot_sum - (SLOT_W+1)'(REGION_BURSTS))
               : slot_sum[SLOT_W-1:0];
      exp_addr = ADDR_W'(32'(exp_slot) * 32'(BEATS));
   end

   mst_pattern #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BEAT_W (BEAT_W)
   ) i_exp_pat (
      .addr (exp_addr),
      .beat (beat_q),
      .word (exp_word)
   );

   assign take = rx_en && rdata_valid;
   assign miss = take && (rdata != exp_word);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q  <= '0;
         burst_q <= '0;
         bad_q   <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (done_q) begin
            if (!bad_q) pass_q <= pass_q + 1'b1;
            bad_q <= 1'b0;
         end
         if (take) begin
            if (miss) begin
               err_q <= 1'b1;
               bad_q <= 1'b1;
            end
            if (beat_q == BEAT_W'(BEATS - 1)) begin
               beat_q <= '0;
               if (burst_q == BURST_W'(NUM_BURSTS - 1)) begin
                  burst_q <= '0;
                  done_q  <= 1'b1;
               end else begin
                  burst_q <= burst_q + 1'b1;
               end
            end else begin
               beat_q <= beat_q + 1'b1;
            end
         end
      end
   end

   assign err        = err_q;
   assign pass_count = pass_q;
   assign loop_done  = done_q;
endmodule

// File: rtl/mem_burst_selftest.sv
module mem_burst_selftest #(
   parameter int ADDR_W        = 21,
   parameter int DQ_W          = 16,
   parameter int BURST_LEN     = 128,
   parameter int NUM_BURSTS    = 4,
   parameter int REGION_BURSTS = 6,
   parameter int PASS_W        = 16,
   localparam int DATA_W       = 4 * DQ_W,
   localparam int MASK_W       = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              calib_done,
   output logic              cmd_valid,
   output logic              cmd_write,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [DATA_W-1:0] wdata,
   output logic [MASK_W-1:0] wmask,
   input  logic [DATA_W-1:0] rdata,
   input  logic              rdata_valid,
   output logic              err,
   output logic [PASS_W-1:0] pass_count
);
   localparam int BEATS   = BURST_LEN / 4;
   localparam int BEAT_W  = mst_pkg::cw(BEATS);
   localparam int SLOT_W  = mst_pkg::cw(REGION_BURSTS);
   localparam int BURST_W = mst_pkg::cw(NUM_BURSTS);

   // elaboration-time parameter checks
   if (BURST_LEN < 4 || (BURST_LEN % 4) != 0) begin : g_bad_burst
      $error("BURST_LEN must be a positive multiple of 4");
   end
   if (BEATS > 256) begin : g_bad_beats
      $error("beat index must fit in eight bits");
   end
   if (DQ_W < 8 || (DQ_W % 8) != 0) begin : g_bad_dq
      $error("DQ_W must be a multiple of 8");
   end
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 16 and 32");
   end
   if (NUM_BURSTS < 1 || NUM_BURSTS > REGION_BURSTS) begin : g_bad_count
      $error("NUM_BURSTS must lie between 1 and REGION_BURSTS");
   end
   if ((64'(REGION_BURSTS) * 64'(BEATS)) > (64'd1 << ADDR_W)) begin : g_bad_region
      $error("test region exceeds the address space");
   end
   if (PASS_W < 1) begin : g_bad_pass
      $error("PASS_W must be at least one");
   end

   logic [BEAT_W-1:0] beat_idx;
   logic [SLOT_W-1:0] base_slot;
   logic              rx_en, loop_done;
   logic [DATA_W-1:0] wr_word;

   mst_issue #(
      .ADDR_W        (ADDR_W),
      .NUM_BURSTS    (NUM_BURSTS),
      .REGION_BURSTS (REGION_BURSTS),
      .BEATS         (BEATS),
      .BEAT_W        (BEAT_W),
      .SLOT_W        (SLOT_W),
      .BURST_W       (BURST_W)
   ) i_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .calib_done (calib_done),
      .loop_done  (loop_done),
      .cmd_valid  (cmd_valid),
      .cmd_write  (cmd_write),
      .cmd_addr   (cmd_addr),
      .beat_idx   (beat_idx),
      .base_slot  (base_slot),
      .rx_en      (rx_en)
   );

   mst_pattern #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .BEAT_W (BEAT_W)
   ) i_wr_pat (
      .addr (cmd_addr),
      .beat (beat_idx),
      .word (wr_word)
   );

   mst_rd_check #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .NUM_BURSTS    (NUM_BURSTS),
      .REGION_BURSTS (REGION_BURSTS),
      .BEATS         (BEATS),
      .PASS_W        (PASS_W),
      .BEAT_W        (BEAT_W),
      .SLOT_W        (SLOT_W),
      .BURST_W       (BURST_W)
   ) i_rd_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_en       (rx_en),
      .rdata_valid (rdata_valid),
      .rdata       (rdata),
      .base_slot   (base_slot),
      .err         (err),
      .pass_count  (pass_count),
      .loop_done   (loop_done)
   );

   assign wdata = cmd_write ? wr_word : '0;
   assign wmask = '0;
endmodule

// File: rtl/mst_selftest_chk.sv
module mst_selftest_chk #(
   parameter int ADDR_W = 21,
   parameter int BEATS  = 32,
   parameter int PASS_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              calib_done,
   input logic              cmd_valid,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              err,
   input logic [PASS_W-1:0] pass_count
);
   logic seen_calib_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          seen_calib_q <= 1'b0;
      else if (calib_done) seen_calib_q <= 1'b1;
   end

   // R1
   no_early_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> seen_calib_q);

   if (BEATS > 1) begin : g_gap
      // R2
      cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cmd_valid |=> !cmd_valid);
   end

   // R4
   addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> ((32'(cmd_addr) % 32'(BEATS)) == 32'd0));

   // R8
   sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R9
   pass_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pass_count == $past(pass_count)) ||
                (pass_count == PASS_W'($past(pass_count) + 1'b1))));
endmodule

bind mem_burst_selftest mst_selftest_chk #(
   .ADDR_W (ADDR_W),
   .BEATS  (BEATS),
   .PASS_W (PASS_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .calib_done (calib_done),
   .cmd_valid  (cmd_valid),
   .cmd_addr   (cmd_addr),
   .err        (err),
   .pass_count (pass_count)
);

// File: tb/test_mem_burst_selftest.sv
module test_mem_burst_selftest;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 21;
   localparam int DQ_W       = 16;
   localparam int BURST_LEN  = 128;
   localparam int NB         = 4;
   localparam int RB         = 6;
   localparam int PASS_W     = 16;
   localparam int DATA_W     = 4 * DQ_W;
   localparam int BEATS      = BURST_LEN / 4;
   localparam int LAT        = 3;
   localparam int LOG_MAX    = 64;

   // expected commands of the first two loops: {write, slot}
   localparam logic [7:0] EXP_CMD [16] = '{
      8'h80, 8'h81, 8'h82, 8'h83, 8'h00, 8'h01, 8'h02, 8'h03,
      8'h84, 8'h85, 8'h80, 8'h81, 8'h04, 8'h05, 8'h00, 8'h01
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              calib_done = 1'b0;
   logic              cmd_valid, cmd_write;
   logic [ADDR_W-1:0] cmd_addr;
   logic [DATA_W-1:0] wdata;
   logic [DATA_W/8-1:0] wmask;
   logic [DATA_W-1:0] rdata = '0;
   logic              rdata_valid = 1'b0;
   logic              err;
   logic [PASS_W-1:0] pass_count;

   mem_burst_selftest #(
      .ADDR_W (ADDR_W), .DQ_W (DQ_W), .BURST_LEN (BURST_LEN),
      .NUM_BURSTS (NB), .REGION_BURSTS (RB), .PASS_W (PASS_W)
   ) i_mem_burst_selftest (
      .clk (clk), .rst_n (rst_n), .calib_done (calib_done),
      .cmd_valid (cmd_valid), .cmd_write (cmd_write), .cmd_addr (cmd_addr),
      .wdata (wdata), .wmask (wmask), .rdata (rdata), .rdata_valid (rdata_valid),
      .err (err), .pass_count (pass_count)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_word(input int a, input int b);
      logic [31:0] a32;
      logic [15:0] f;
      logic [63:0] w;
      a32 = 32'(a);
      f = a32[15:0] ^ a32[31:16] ^ 16'hC3A5;
      for (int j = 0; j < DATA_W/32; j++) w[32*j +: 32] = {f, 8'(b), 8'(j)};
      return w;
   endfunction

   // memory model and monitor state
   logic [63:0] mem [RB*BEATS];
   int  log_addr [LOG_MAX];
   bit  log_w    [LOG_MAX];
   int  log_cyc  [LOG_MAX];
   int  cmd_n = 0;
   bit  wr_act = 0;
   int  wr_base = 0, wr_idx = 0;
   int  rq_a [$];
   int  rq_t [$];
   bit  rs_act = 0;
   int  rs_addr = 0, rs_idx = 0;
   bit  gappy = 0, toggle = 0, spur = 0, corrupt = 0;
   bit  wait_gap = 0;
   int  last_beat_cyc = 0;

   always @(negedge clk) begin
      rdata_valid = 1'b0;
      if (!rst_n) begin
         wr_act = 0; rs_act = 0; wait_gap = 0; toggle = 0;
         rq_a.delete(); rq_t.delete();
      end else begin
         if (cmd_valid) begin
            if (cmd_n < LOG_MAX) begin
               log_addr[cmd_n] = int'(cmd_addr);
               log_w[cmd_n]    = cmd_write;
               log_cyc[cmd_n]  = cyc;
            end
            if (cmd_write && wait_gap) begin
               // R7: next loop starts two cycles after the final beat
               chk((cyc - last_beat_cyc) == 2, "R7", "loop restart delay",
                   64'(cyc - last_beat_cyc), 64'd2);
               wait_gap = 0;
            end
            cmd_n++;
            if (cmd_write) begin
               wr_act = 1; wr_base = int'(cmd_addr); wr_idx = 0;
            end else begin
               rq_a.push_back(int'(cmd_addr));
               rq_t.push_back(cyc + LAT);
            end
         end
         if (wr_act) begin
            chk(wdata == exp_word(wr_base, wr_idx), "R5", "write beat", wdata,
                exp_word(wr_base, wr_idx));
            if (wr_idx == 0) chk(wmask == '0, "R6", "write mask", 64'(wmask), 64'd0);
            mem[wr_base + wr_idx] = wdata;
            wr_idx++;
            if (wr_idx == BEATS) wr_act = 0;
         end
         if (!rs_act && rq_a.size() > 0 && cyc >= rq_t[0]) begin
            rs_act = 1; rs_addr = rq_a.pop_front(); rs_idx = 0;
            void'(rq_t.pop_front());
         end
         if (rs_act) begin
            if (gappy && toggle) begin
               toggle = 0;
            end else begin
               toggle = 1;
               rdata_valid = 1'b1;
               rdata = mem[rs_addr + rs_idx];
               if (corrupt && rs_idx == 5) begin
                  rdata = rdata ^ 64'h100;
                  corrupt = 0;
               end
               rs_idx++;
               if (rs_idx == BEATS) begin
                  rs_act = 0;
                  if (rq_a.size() == 0) begin
                     last_beat_cyc = cyc; wait_gap = 1;
                  end
               end
            end
         end else if (spur && wr_act) begin
            rdata_valid = 1'b1;
            rdata = 64'hDEAD_BEEF_0BAD_F00D;
         end
      end
   end

   task automatic wait_cmds(input int n);
      while (cmd_n < n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int idx;
      repeat (4) @(negedge clk);
      // R10: reset state
      chk(cmd_valid == 0, "R10", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
      chk(err == 0, "R10", "err in reset", 64'(err), 64'd0);
      chk(pass_count == 0, "R10", "pass_count in reset", 64'(pass_count), 64'd0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      // R1: nothing before calibration
      chk(cmd_n == 0, "R1", "commands before calib", 64'(cmd_n), 64'd0);
      calib_done = 1'b1;

      wait_cmds(17);
      for (int i = 0; i < 16; i++) begin
         chk(log_w[i] == EXP_CMD[i][7], (EXP_CMD[i][7] ? "R2" : "R3"),
             $sformatf("command %0d kind", i), 64'(log_w[i]), 64'(EXP_CMD[i][7]));
         chk(log_addr[i] == int'(EXP_CMD[i][6:0]) * BEATS, "R4",
             $sformatf("command %0d address", i), 64'(log_addr[i]),
             64'(int'(EXP_CMD[i][6:0]) * BEATS));
         if ((i % 8) != 0)
            chk((log_cyc[i] - log_cyc[i-1]) == BEATS, ((i % 8) < 4 ? "R2" : "R3"),
                $sformatf("command %0d spacing", i), 64'(log_cyc[i] - log_cyc[i-1]),
                64'(BEATS));
      end
      chk(pass_count == 2, "R9", "pass after two clean loops", 64'(pass_count), 64'd2);
      chk(err == 0, "R8", "err after clean loops", 64'(err), 64'd0);

      // R7: gaps in read data and spurious valid during writes
      gappy = 1; spur = 1;
      wait_cmds(25);
      chk(err == 0, "R7", "err after spurious valid", 64'(err), 64'd0);
      chk(pass_count == 3, "R7", "pass after gapped loop", 64'(pass_count), 64'd3);

      gappy = 0; spur = 0; corrupt = 1;
      wait_cmds(33);
      chk(err == 1, "R8", "err after corrupt beat", 64'(err), 64'd1);
      chk(pass_count == 3, "R9", "pass after bad loop", 64'(pass_count), 64'd3);

      wait_cmds(41);
      chk(err == 1, "R8", "err sticky", 64'(err), 64'd1);
      chk(pass_count == 4, "R9", "pass after later clean loop", 64'(pass_count), 64'd4);

      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(err == 0, "R10", "err cleared", 64'(err), 64'd0);
      chk(pass_count == 0, "R10", "pass cleared", 64'(pass_count), 64'd0);
      chk(cmd_valid == 0, "R10", "cmd_valid in reset", 64'(cmd_valid), 64'd0);
      idx = cmd_n;
      rst_n = 1'b1;
      wait_cmds(idx + 1);
      if (idx < LOG_MAX) begin
         chk(log_w[idx] == 1'b1, "R10", "first command after reset", 64'(log_w[idx]), 64'd1);
         chk(log_addr[idx] == 0, "R10", "restart slot", 64'(log_addr[idx]), 64'd0);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule